// File: doc/BRIEF.md
# Reference Tick Divider and Clock Control Registers

This unit holds the clock configuration that software writes through a small register port. The first value is a 10-bit pre-divide count for the CPU clock. The second set is four 8-bit tick dividers, one for each clock that can drive the bus: crystal, main PLL, internal fast RC oscillator and audio PLL. The third value is a fixed revision word. The unit does not switch any clocks itself. It publishes the pre-divide count and produces a reference tick enable.

The tick enable is a pulse one bus cycle wide. It repeats every N+1 bus cycles, where N is the divider that belongs to the source currently named on the source-select input. When the selected source changes, or when its divider changes, the tick counter starts again. A new period therefore never begins with a short interval.

The unit also decides whether the audio PLL is powered. It combines a force-on control, a force-off control and the system sleep state to make that decision.

Top module: `refclk_ctrl`

## Requirements
- R1: After reset, the registers read back as follows: 0x00 (pre-divide) reads 0, 0x04 (crystal divider) reads 39, 0x08 (main PLL divider) reads 79, 0x0C (fast RC divider) reads 11, 0x3C (audio PLL divider) reads 99, and 0x7C (revision) reads 0x16042000. The `cpu_prediv` output reads 0.
- R2: A request with `req_valid`=1 and `req_write`=1 stores the data at that clock edge. A read request places its data on `rsp_rdata` at the next clock edge, and `rsp_rdata` holds that value until the next read.
- R3: The pre-divide field is bits 9:0 of offset 0x00 and drives `cpu_prediv`. Each divider is bits 7:0 of its own offset. Bits above a field ignore writes and read as zero.
- R4: Writes to the revision word are ignored. Reads of any other unmapped offset return zero. Writes to unmapped offsets change no register.
- R5: `src_sel` picks the active divider N: 0 picks crystal, 1 picks main PLL, 2 picks fast RC and 3 picks audio PLL. With a steady configuration, `tick` is high for one cycle in every N+1 cycles. This holds for the boundary value N=255.
- R6: When N=0, `tick` is high on every cycle.
- R7: A change of `src_sel` restarts the counter. The first tick appears in the (N+1)-th cycle after the edge that samples the change.
- R8: A write that changes the active divider restarts the counter in the same way as a source change.
- R9: When `apll_force_off`=1, `apll_pwr_up` is 0, whatever the other inputs are.
- R10: When `apll_force_on`=1 and `apll_force_off`=0, `apll_pwr_up` is 1 even while asleep. When both force inputs are 0, `apll_pwr_up` equals the inverse of `asleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| src_sel | input | 2 | Active bus-clock source |
| asleep | input | 1 | System sleep state |
| apll_force_on | input | 1 | Force the audio PLL on |
| apll_force_off | input | 1 | Force the audio PLL off; takes priority over force-on |
| cpu_prediv | output | 10 | CPU clock pre-divide count |
| tick | output | 1 | Reference tick enable pulse |
| apll_pwr_up | output | 1 | Audio PLL power-up request |

## Verification
The tick is measured for each of the four sources, each set to a different small divider. A wrong index into the divider bank therefore shows up as a wrong gap. The extreme values N=0 and N=255 separate an off-by-one in the wrap from a counter that is too narrow.

Source switches and divider rewrites are timed from the change to the first tick. This tells a real restart apart from a counter that simply carries on.

All-ones writes, writes to the revision word and accesses to unmapped offsets show which register bits are actually stored. The audio PLL power output is driven through every combination of the force inputs and the sleep input, which shows both the priority between the force inputs and the fallback that follows sleep.

// File: rtl/refclk_ctrl.sv
module refclk_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 10,
  parameter int TICK_W = 8,
  parameter logic [DATA_W-1:0] REV_WORD = 32'h1604_2000,
  parameter int RST_XTAL = 39,
  parameter int RST_MPLL = 79,
  parameter int RST_FRC  = 11,
  parameter int RST_APLL = 99
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [1:0]        src_sel,
  input  logic              asleep,
  input  logic              apll_force_on,
  input  logic              apll_force_off,
  output logic [PRE_W-1:0]  cpu_prediv,
  output logic              tick,
  output logic              apll_pwr_up
);
  localparam logic [ADDR_W-1:0] OFF_PRE  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_XTAL = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_MPLL = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFF_FRC  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFF_APLL = ADDR_W'('h3C);
  localparam logic [ADDR_W-1:0] OFF_REV  = ADDR_W'('h7C);

  logic [PRE_W-1:0]  prediv_q;
  logic [TICK_W-1:0] tdiv_q [4];
  logic [DATA_W-1:0] rd_val;
  logic [TICK_W-1:0] act_n, n_q, cnt;
  logic [1:0]        sel_q;
  logic              restart;
  logic              unused_wdata;

  assign unused_wdata = ^req_wdata[DATA_W-1:PRE_W];
  assign cpu_prediv   = prediv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prediv_q  <= '0;
      tdiv_q[0] <= TICK_W'(RST_XTAL);
      tdiv_q[1] <= TICK_W'(RST_MPLL);
      tdiv_q[2] <= TICK_W'(RST_FRC);
      tdiv_q[3] <= TICK_W'(RST_APLL);
    end else if (req_valid && req_write) begin
      case (req_addr)
        OFF_PRE:  prediv_q  <= req_wdata[PRE_W-1:0];
        OFF_XTAL: tdiv_q[0] <= req_wdata[TICK_W-1:0];
        OFF_MPLL: tdiv_q[1] <= req_wdata[TICK_W-1:0];
        OFF_FRC:  tdiv_q[2] <= req_wdata[TICK_W-1:0];
        OFF_APLL: tdiv_q[3] <= req_wdata[TICK_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (req_addr)
      OFF_PRE:  rd_val = DATA_W'(prediv_q);
      OFF_XTAL: rd_val = DATA_W'(tdiv_q[0]);
      OFF_MPLL: rd_val = DATA_W'(tdiv_q[1]);
      OFF_FRC:  rd_val = DATA_W'(tdiv_q[2]);
      OFF_APLL: rd_val = DATA_W'(tdiv_q[3]);
      OFF_REV:  rd_val = REV_WORD;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                         rsp_rdata <= '0;
    else if (req_valid && !req_write) rsp_rdata <= rd_val;
  end

  // R2
  rev_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr == OFF_REV) |=> rsp_rdata == REV_WORD);

  assign act_n   = tdiv_q[src_sel];
  assign restart = (src_sel != sel_q) || (act_n != n_q);
  assign tick    = (cnt == n_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 2'd0;
      n_q   <= TICK_W'(RST_XTAL);
      cnt   <= '0;
    end else if (restart) begin
      sel_q <= src_sel;
      n_q   <= act_n;
      cnt   <= '0;
    end else if (cnt == n_q) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= n_q);

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && n_q != '0) |=> !tick);

  // R7
  sel_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (src_sel != sel_q) |=> (cnt == '0));

  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart && n_q == '0) |=> tick);

  assign apll_pwr_up = !apll_force_off && (apll_force_on || !asleep);

  // R9
  force_off_chk: assert property (@(posedge clk) disable iff (rst)
    apll_force_off |-> !apll_pwr_up);

  // R10
  sleep_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!apll_force_off && !apll_force_on) |-> (apll_pwr_up == !asleep));
endmodule

// File: tb/refclk_ctrl_test.sv
module refclk_ctrl_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [1:0]  src_sel = 2'd0;
  logic        asleep = 0, apll_force_on = 0, apll_force_off = 0;
  logic [9:0]  cpu_prediv;
  logic        tick, apll_pwr_up;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  refclk_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .src_sel(src_sel), .asleep(asleep), .apll_force_on(apll_force_on),
    .apll_force_off(apll_force_off), .cpu_prediv(cpu_prediv),
    .tick(tick), .apll_pwr_up(apll_pwr_up)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    bus_read(a, d);
    check(d == exp, req, d, exp);
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 2000);
  endtask

  task automatic expect_gap(input int exp, input string req);
    int n;
    wait_tick(n);
    wait_tick(n);
    check(n == exp, req, n, exp);
  endtask

  task automatic t_reset;
    expect_reg(8'h00, 32'd0, "R1 prediv");
    expect_reg(8'h04, 32'd39, "R1 crystal div");
    expect_reg(8'h08, 32'd79, "R1 main pll div");
    expect_reg(8'h0C, 32'd11, "R1 fast rc div");
    expect_reg(8'h3C, 32'd99, "R1 audio pll div");
    expect_reg(8'h7C, 32'h1604_2000, "R1 revision");
    check(cpu_prediv == 0, "R1 cpu_prediv", cpu_prediv, 0);
    expect_gap(40, "R5 reset crystal period");
  endtask

  task automatic t_readwrite;
    logic [31:0] d;
    bus_write(8'h00, 32'h155);
    expect_reg(8'h00, 32'h155, "R2 prediv readback");
    check(cpu_prediv == 10'h155, "R3 cpu_prediv", cpu_prediv, 10'h155);
    bus_write(8'h0C, 32'h5A);
    expect_reg(8'h0C, 32'h5A, "R2 fast rc readback");
    @(negedge clk);
    check(rsp_rdata == 32'h5A, "R2 rdata holds", rsp_rdata, 32'h5A);
    bus_read(8'h00, d);
    check(d == 32'h155, "R2 latency", d, 32'h155);
  endtask

  task automatic t_widths;
    bus_write(8'h00, 32'hFFFF_FFFF);
    expect_reg(8'h00, 32'h3FF, "R3 prediv width");
    check(cpu_prediv == 10'h3FF, "R3 cpu_prediv all ones", cpu_prediv, 10'h3FF);
    bus_write(8'h08, 32'hFFFF_FF12);
    expect_reg(8'h08, 32'h12, "R3 divider width");
  endtask

  task automatic t_readonly;
    bus_write(8'h7C, 32'h0);
    expect_reg(8'h7C, 32'h1604_2000, "R4 revision write ignored");
    bus_write(8'h40, 32'hDEAD_BEEF);
    expect_reg(8'h40, 32'h0, "R4 unmapped read zero");
    expect_reg(8'h10, 32'h0, "R4 unmapped 0x10");
    expect_reg(8'h06, 32'h0, "R4 unaligned offset");
    expect_reg(8'h04, 32'd39, "R4 crystal untouched");
    expect_reg(8'h3C, 32'd99, "R4 audio untouched");
    expect_reg(8'h00, 32'h3FF, "R4 prediv untouched");
  endtask

  task automatic t_periods;
    bus_write(8'h04, 32'd5);
    bus_write(8'h08, 32'd9);
    bus_write(8'h0C, 32'd3);
    bus_write(8'h3C, 32'd14);
    src_sel = 2'd0; expect_gap(6, "R5 crystal sel0");
    src_sel = 2'd1; expect_gap(10, "R5 main pll sel1");
    src_sel = 2'd2; expect_gap(4, "R5 fast rc sel2");
    src_sel = 2'd3; expect_gap(15, "R5 audio pll sel3");
    bus_write(8'h3C, 32'd255);
    expect_gap(256, "R5 N=255");
  endtask

  task automatic t_zero;
    bus_write(8'h0C, 32'd0);
    @(negedge clk);
    src_sel = 2'd2;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(tick == 1'b1, "R6 tick every cycle", tick, 1);
    end
  endtask

  task automatic t_restart;
    int n;
    bus_write(8'h08, 32'd20);
    @(negedge clk);
    src_sel = 2'd1;
    wait_tick(n);
    check(n == 21, "R7 first tick after source change", n, 21);
    wait_tick(n);
    wait_tick(n);
    repeat (7) @(negedge clk);
    src_sel = 2'd0;
    wait_tick(n);
    check(n == 6, "R7 switch mid-count", n, 6);
    repeat (3) @(negedge clk);
    bus_write(8'h04, 32'd12);
    wait_tick(n);
    check(n == 13, "R8 restart on divider write", n, 13);
    expect_gap(13, "R8 new period");
  endtask

  task automatic t_apll;
    for (int i = 0; i < 8; i++) begin
      bit off, on, slp, exp;
      {off, on, slp} = 3'(i);
      @(negedge clk);
      apll_force_off = off; apll_force_on = on; asleep = slp;
      @(negedge clk);
      exp = off ? 1'b0 : (on ? 1'b1 : !slp);
      if (off) check(apll_pwr_up == exp, "R9 force off wins", apll_pwr_up, exp);
      else     check(apll_pwr_up == exp, "R10 force on / sleep follow", apll_pwr_up, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_readwrite();
    t_widths();
    t_readonly();
    t_periods();
    t_zero();
    t_restart();
    t_apll();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule